// File: doc/BRIEF.md
# DMA RAM Address Pointer Bank

This block keeps one 16-bit RAM address pointer per DMA channel. Each pointer names the RAM location that the channel reads from or writes to. The pointer moves forward by itself each time the channel finishes moving one unit. The step is one in byte mode and two in halfword mode. Once the last unit has moved, the pointer rests one step beyond the final address that was used.

The CPU reaches the pointers through a simple bus. It picks a channel and writes either or both bytes, using byte enables. The pointer can always be read back. Writes to a channel are dropped while that channel's transfer is active. For each channel, the block drives a 20-bit effective address: the pointer with a fixed 0xF nibble placed above it, and with bit 0 cleared in halfword mode. Next to each address sits a flag that marks addresses outside the legal RAM window.

Top module: `dma_ptr_bank`

## Requirements
- R1: After reset every pointer reads 0x0000. Every effective address is then 0xF0000, and every illegal flag is 1.
- R2: When a channel is active, in byte mode (wide_mode bit 0) and gets a unit_done pulse, its pointer grows by 1 at the next clock edge.
- R3: When a channel is active, in halfword mode (wide_mode bit 1) and gets a unit_done pulse, its stored pointer grows by 2. This holds even when the stored low bit is 1.
- R4: A unit_done pulse on a channel whose xfer_active bit is 0 leaves that pointer unchanged.
- R5: A CPU write to a channel whose xfer_active bit is 1 is ignored. A write to another, inactive channel still takes effect.
- R6: A CPU write updates only the enabled bytes of the channel chosen by cpu_sel. cpu_be bit 0 selects pointer bits 7:0 from cpu_wdata[7:0]. cpu_be bit 1 selects bits 15:8 from cpu_wdata[15:8].
- R7: Bits 19:16 of each effective address are 0xF and bits 15:0 are the pointer. In halfword mode bit 0 is driven as 0, but cpu_rdata still returns the stored bit 0.
- R8: The illegal flag is 1 exactly when the effective address is below 0xFF900 or above 0xFFEDF.
- R9: Pointer growth wraps modulo 2^16. In byte mode 0xFFFF goes to 0x0000, and in halfword mode 0xFFFE goes to 0x0000.
- R10: cpu_rdata shows, in the same cycle, the stored pointer of the channel chosen by cpu_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Channel chosen for CPU access |
| cpu_we | input | 1 | CPU write strobe |
| cpu_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Stored pointer of the chosen channel |
| xfer_active | input | 2 | Per-channel flag: transfer in progress |
| wide_mode | input | 2 | Per-channel width: 1 = halfword, 0 = byte |
| unit_done | input | 2 | Per-channel strobe: one unit has moved |
| eff_addr | output | 40 | Per-channel 20-bit effective address; channel c sits at bits [20c+19:20c] |
| addr_illegal | output | 2 | Per-channel flag: effective address outside the legal window |

## Verification
The bench builds the block with its default values: two channels and the window 0xFF900 to 0xFFEDF. With two channels, one channel can be locked by an active transfer while the CPU writes to the other, so the lock is seen to act on one channel only. The 16-bit pointer lets the bench reach, in a few cycles, the wrap at 0xFFFF and both edges of the legal window (0xF8FF/0xF900 and 0xFEDF/0xFEE0). Constrained-random cycles then mix writes, strobes and mode changes on both channels against a model kept in the bench.

// File: rtl/dma_ptr_bank.sv
module dma_ptr_bank #(
  parameter int NCH = 2,
  parameter int PW = 16,
  parameter int AW = 20,
  parameter logic [AW-1:0] WIN_LO = 20'hFF900,
  parameter logic [AW-1:0] WIN_HI = 20'hFFEDF,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW = PW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHW-1:0]    cpu_sel,
  input  logic              cpu_we,
  input  logic [BW-1:0]     cpu_be,
  input  logic [PW-1:0]     cpu_wdata,
  output logic [PW-1:0]     cpu_rdata,
  input  logic [NCH-1:0]    xfer_active,
  input  logic [NCH-1:0]    wide_mode,
  input  logic [NCH-1:0]    unit_done,
  output logic [NCH*AW-1:0] eff_addr,
  output logic [NCH-1:0]    addr_illegal
);
  localparam logic [AW-PW-1:0] PREFIX = '1;

  logic [NCH-1:0][PW-1:0] ptr;

  assign cpu_rdata = ptr[cpu_sel];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          step_en, wr_en;
    logic [PW-1:0] step, merged, drv;
    logic [AW-1:0] ea;

    assign step_en = xfer_active[c] && unit_done[c];
    assign wr_en   = cpu_we && (cpu_sel == CHW'(c)) && !xfer_active[c];
    assign step    = wide_mode[c] ? PW'(2) : PW'(1);

    for (genvar b = 0; b < BW; b++) begin : g_byte
      assign merged[8*b +: 8] = cpu_be[b] ? cpu_wdata[8*b +: 8] : ptr[c][8*b +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       ptr[c] <= '0;
      else if (step_en) ptr[c] <= ptr[c] + step;
      else if (wr_en)   ptr[c] <= merged;
    end

    assign drv = {ptr[c][PW-1:1], ptr[c][0] & ~wide_mode[c]};
    assign ea  = {PREFIX, drv};
    assign eff_addr[c*AW +: AW] = ea;
    assign addr_illegal[c] = (ea < WIN_LO) || (ea > WIN_HI);
  end
endmodule

// File: rtl/dma_ptr_bank_chk.sv
module dma_ptr_bank_chk #(
  parameter int NCH = 2,
  parameter int PW = 16,
  parameter int AW = 20,
  parameter int CHW = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_we,
  input logic [CHW-1:0]         cpu_sel,
  input logic [NCH-1:0]         xfer_active,
  input logic [NCH-1:0]         wide_mode,
  input logic [NCH-1:0]         unit_done,
  input logic [NCH-1:0][PW-1:0] ptr,
  input logic [NCH*AW-1:0]      eff_addr
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_byte_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active[c] && unit_done[c] && !wide_mode[c]) |=> ptr[c] == $past(ptr[c]) + PW'(1));
    assert_half_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active[c] && unit_done[c] && wide_mode[c]) |=> ptr[c] == $past(ptr[c]) + PW'(2));
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_active[c] && !(cpu_we && cpu_sel == CHW'(c))) |=> $stable(ptr[c]));
    assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active[c] && !unit_done[c]) |=> $stable(ptr[c]));
    assert_even_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wide_mode[c] |-> (eff_addr[c*AW] == 1'b0 && eff_addr[c*AW+PW +: AW-PW] == '1));
  end
endmodule

bind dma_ptr_bank dma_ptr_bank_chk #(.NCH(NCH), .PW(PW), .AW(AW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
  .xfer_active(xfer_active), .wide_mode(wide_mode), .unit_done(unit_done),
  .ptr(ptr), .eff_addr(eff_addr)
);

// File: tb/dma_ptr_bank_test.sv
module dma_ptr_bank_test;
  logic        clk = 0, rst_n = 0;
  logic        cpu_sel = 0, cpu_we = 0;
  logic [1:0]  cpu_be = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata;
  logic [1:0]  xfer_active = 0, wide_mode = 0, unit_done = 0;
  logic [39:0] eff_addr;
  logic [1:0]  addr_illegal;

  logic [15:0] mdl [2];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_ptr_bank uut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .xfer_active(xfer_active),
    .wide_mode(wide_mode), .unit_done(unit_done), .eff_addr(eff_addr),
    .addr_illegal(addr_illegal)
  );

  function automatic logic [19:0] exp_ea(logic [15:0] p, logic w);
    return {4'hF, p[15:1], p[0] & ~w};
  endfunction

  function automatic logic exp_bad(logic [19:0] e);
    return (e < 20'hFF900) || (e > 20'hFFEDF);
  endfunction

  task automatic chk(string tag, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " R10 rdata"}, 20'(cpu_rdata), 20'(mdl[cpu_sel]));
    for (int c = 0; c < 2; c++) begin
      chk({tag, " R7 eff"}, eff_addr[c*20 +: 20], exp_ea(mdl[c], wide_mode[c]));
      chk({tag, " R8 illegal"}, 20'(addr_illegal[c]), 20'(exp_bad(exp_ea(mdl[c], wide_mode[c]))));
    end
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (xfer_active[c] && unit_done[c]) mdl[c] = mdl[c] + (wide_mode[c] ? 16'd2 : 16'd1);
      else if (cpu_we && cpu_sel == c[0] && !xfer_active[c]) begin
        if (cpu_be[0]) mdl[c][7:0] = cpu_wdata[7:0];
        if (cpu_be[1]) mdl[c][15:8] = cpu_wdata[15:8];
      end
    end
    @(negedge clk);
    cpu_we = 0; unit_done = 0;
    compare(tag);
  endtask

  task automatic wr(logic ch, logic [1:0] be, logic [15:0] d, string tag);
    cpu_sel = ch; cpu_we = 1; cpu_be = be; cpu_wdata = d;
    cycle(tag);
  endtask

  task automatic done(logic [1:0] m, string tag);
    unit_done = m;
    cycle(tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    mdl[0] = 0; mdl[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");
    cpu_sel = 1; #1 compare("R1 reset ch1");

    wr(0, 2'b11, 16'hF900, "R6 full");
    wr(0, 2'b11, 16'hF8FF, "R8 below");
    wr(0, 2'b11, 16'hFEDF, "R8 top");
    wr(0, 2'b11, 16'hFEE0, "R8 above");
    wr(1, 2'b01, 16'h12AB, "R6 low byte");
    wr(1, 2'b10, 16'hCD34, "R6 high byte");
    wr(1, 2'b00, 16'h0000, "R6 no byte");

    wr(0, 2'b11, 16'hF901, "R7 setup");
    wide_mode = 2'b01; xfer_active = 2'b01;
    cycle("R7 odd wide");
    done(2'b01, "R3 wide step");
    wr(0, 2'b11, 16'h1111, "R5 locked");
    wr(1, 2'b11, 16'hF955, "R5 other free");
    wide_mode = 0;
    done(2'b01, "R2 byte step");
    done(2'b11, "R4 inactive done");
    xfer_active = 0;
    done(2'b11, "R4 no active");

    wr(0, 2'b11, 16'hFFFF, "R9 setup");
    xfer_active = 2'b01;
    done(2'b01, "R9 byte wrap");
    xfer_active = 0;
    wr(1, 2'b11, 16'hFFFE, "R9 setup wide");
    xfer_active = 2'b10; wide_mode = 2'b10;
    done(2'b10, "R9 wide wrap");
    xfer_active = 0;

    for (int i = 0; i < 3000; i++) begin
      xfer_active = 2'($urandom);
      wide_mode = 2'($urandom);
      unit_done = 2'($urandom);
      cpu_sel = 1'($urandom);
      cpu_we = ($urandom % 3) == 0;
      cpu_be = 2'($urandom);
      cpu_wdata = ($urandom % 2) ? 16'($urandom) : 16'hF900 + 16'($urandom % 16'h600);
      cycle("random R2 R3 R5 R6");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule